// File: doc/BRIEF.md
# Wrapping Linear Burst Read Sequencer

This block turns a single start strobe into a synchronous burst of word reads from a 32-bit-wide array. Software first writes a 16-bit configuration word that selects the burst length (4 or 8 words) and the initial access latency in clocks. When the chip is selected and the start strobe is sampled low on a rising clock edge, the block captures the start address and waits the programmed latency. It then issues one array address per clock. The addresses walk through the aligned 4- or 8-word group that contains the start address and wrap back to the group base after its top word.

A registered array model returns one data word per issued address, one clock later. An active-low end indicator marks the final data word of each burst. A separate output-enable flag tells the pad logic when that indicator is driven. While the chip is deselected the flag is low, and the indicator is meant to float. A fresh strobe restarts the sequence at once. Deselecting the chip abandons the burst.

Top module: `bseq_top`

## Requirements
- R1: After reset, no address or data is valid, `ind_n` is 1, and the configuration holds an 8-word burst with a latency of 13 clocks.
- R2: The configuration word uses bits 13:10 as the latency code L (in clocks) and bits 2:0 as the length code: 3'b010 selects 4 words and 3'b011 selects 8 words. A write with a valid latency takes effect for the next burst.
- R3: Latency codes 0, 1, 14 and 15 are invalid. A write that carries one is discarded completely, and the previous configuration stays in force.
- R4: A burst starts on a rising edge where `ce_n`=0 and `adv_n`=0. The first address is valid after the L-th following edge, and each address's data is valid one clock after it.
- R5: A 4-word burst issues addresses inside the aligned 4-word group, beginning at the start offset and wrapping. For example, offset 1 gives 1,2,3,0.
- R6: An 8-word burst does the same inside the aligned 8-word group. For example, offset 5 gives 5,6,7,0,1,2,3,4.
- R7: Length codes other than 3'b010 and 3'b011 disable bursting. The start strobe is then ignored and `addr_valid` stays 0.
- R8: A start strobe during a burst abandons it and begins a new burst from the new address with the full latency.
- R9: `ce_n`=1 at a rising edge ends any burst. `addr_valid` is 0 after that edge.
- R10: `ind_n` is 0 exactly in the cycle the last data word of a burst is valid, and 1 in every other cycle.
- R11: `ind_oe` is 0 whenever `ce_n` is 1, and 1 whenever `ce_n` is 0.
- R12: After the last address of a burst, `addr_valid` drops and `rd_addr` holds that last address until the next start.
- R13: The data word at address a is 32'hC0DE0000 + 5*a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| ce_n | input | 1 | Active-low chip select |
| adv_n | input | 1 | Active-low start strobe |
| start_addr | input | AW (6) | Burst start address |
| rd_addr | output | AW (6) | Issued array address |
| addr_valid | output | 1 | `rd_addr` is a live burst address |
| rd_data | output | 32 | Array data word |
| data_valid | output | 1 | `rd_data` is a live burst word |
| ind_n | output | 1 | Active-low end-of-burst indicator |
| ind_oe | output | 1 | Drive enable for `ind_n` |

## Verification
A latency counter that is off by one moves the whole address and data train by one clock. It therefore shows up on the very first expected address of a burst. A wrong wrap mask or beat counter sends `rd_addr` out of its aligned group, or repeats a word, within the group's length. An end indicator that is out of step with the beat count is visible one cycle after the final address. A configuration register that takes an invalid write is exposed by the next burst's timing and length.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int CFG_W   = 16;
  localparam int LAT_W   = 4;
  localparam int LEN_W   = 3;
  localparam int LAT_LSB = 10;
  localparam int LAT_MIN = 2;
  localparam int LAT_MAX = 13;
  localparam logic [LEN_W-1:0] LEN_CODE_4 = 3'b010;
  localparam logic [LEN_W-1:0] LEN_CODE_8 = 3'b011;
  localparam logic [LAT_W-1:0] LAT_RESET  = LAT_W'(LAT_MAX);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} seq_state_t;

  function automatic logic lat_ok(input logic [LAT_W-1:0] code);
    return (int'(code) >= LAT_MIN) && (int'(code) <= LAT_MAX);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'hC0DE_0000 + a * 32'd5;
  endfunction
endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [LAT_W-1:0] lat,
  output logic             burst_ok,
  output logic             len8
);
  logic [LEN_W-1:0] len_q;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] wr_lat;
  logic             wr_accept;

  assign wr_lat    = cfg_wdata[LAT_LSB +: LAT_W];
  assign wr_accept = cfg_we && lat_ok(wr_lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= LAT_RESET;
      len_q <= LEN_CODE_8;
    end else if (wr_accept) begin
      lat_q <= wr_lat;
      len_q <= cfg_wdata[LEN_W-1:0];
    end
  end

  assign lat      = lat_q;
  assign burst_ok = (len_q == LEN_CODE_4) || (len_q == LEN_CODE_8);
  assign len8     = (len_q == LEN_CODE_8);

  AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lat_ok(wr_lat)) |=> ($stable(lat_q) && $stable(len_q))); // R3
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import bseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    start_addr,
  input  logic [LAT_W-1:0] lat,
  input  logic             burst_ok,
  input  logic             len8,
  output logic [AW-1:0]    rd_addr,
  output logic             addr_valid,
  output logic             addr_last
);
  localparam int BEAT_W = 3;

  seq_state_t        state;
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beats_m1;
  logic [LAT_W-1:0]  cnt_q;
  logic              len8_q;
  logic              start_w;
  logic              final_beat;

  function automatic logic [AW-1:0] wrap_addr(input logic [AW-1:0] base,
                                              input logic [BEAT_W-1:0] beat,
                                              input logic is8);
    logic [AW-1:0] mask;
    mask = is8 ? AW'(7) : AW'(3);
    return (base & ~mask) | ((base + AW'(beat)) & mask);
  endfunction

  assign start_w    = !ce_n && !adv_n && burst_ok;
  assign beats_m1   = len8_q ? BEAT_W'(7) : BEAT_W'(3);
  assign final_beat = (state == ST_RUN) && (beat_q == beats_m1);
  assign addr_last  = addr_valid && final_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base_q     <= '0;
      beat_q     <= '0;
      cnt_q      <= '0;
      len8_q     <= 1'b1;
      rd_addr    <= '0;
      addr_valid <= 1'b0;
    end else if (ce_n) begin
      state      <= ST_IDLE;
      addr_valid <= 1'b0;
    end else if (start_w) begin
      state      <= ST_WAIT;
      base_q     <= start_addr;
      len8_q     <= len8;
      cnt_q      <= lat;
      beat_q     <= '0;
      addr_valid <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (cnt_q == LAT_W'(1)) begin
            state      <= ST_RUN;
            beat_q     <= '0;
            rd_addr    <= wrap_addr(base_q, '0, len8_q);
            addr_valid <= 1'b1;
          end else begin
            cnt_q <= cnt_q - LAT_W'(1);
          end
        end
        ST_RUN: begin
          if (final_beat) begin
            state      <= ST_IDLE;
            addr_valid <= 1'b0;
          end else begin
            beat_q     <= beat_q + BEAT_W'(1);
            rd_addr    <= wrap_addr(base_q, beat_q + BEAT_W'(1), len8_q);
            addr_valid <= 1'b1;
          end
        end
        default: addr_valid <= 1'b0;
      endcase
    end
  end

  AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RUN && state == ST_RUN && addr_valid)
      |-> (rd_addr[AW-1:3] == $past(rd_addr[AW-1:3]))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_w) |=> ($stable(rd_addr) && !addr_valid)); // R12
  AST_NO_BURST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_ok && state == ST_IDLE) |=> (state == ST_IDLE)); // R7
  AST_ABORT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !addr_valid); // R9
endmodule

// File: rtl/bseq_mem.sv
module bseq_mem
  import bseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          addr_valid,
  input  logic          addr_last,
  output logic [31:0]   rd_data,
  output logic          data_valid,
  output logic          data_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      data_valid <= 1'b0;
      data_last  <= 1'b0;
    end else begin
      data_valid <= addr_valid;
      data_last  <= addr_last;
      if (addr_valid) rd_data <= mem_word(32'(rd_addr));
    end
  end

  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> data_valid); // R4
endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    start_addr,
  output logic [AW-1:0]    rd_addr,
  output logic             addr_valid,
  output logic [31:0]      rd_data,
  output logic             data_valid,
  output logic             ind_n,
  output logic             ind_oe
);
  logic [LAT_W-1:0] lat;
  logic             burst_ok;
  logic             len8;
  logic             addr_last;
  logic             data_last;

  bseq_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lat(lat), .burst_ok(burst_ok), .len8(len8)
  );

  bseq_addr_gen #(.AW(AW)) i_gen (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
    .start_addr(start_addr), .lat(lat), .burst_ok(burst_ok), .len8(len8),
    .rd_addr(rd_addr), .addr_valid(addr_valid), .addr_last(addr_last)
  );

  bseq_mem #(.AW(AW)) i_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_valid(addr_valid),
    .addr_last(addr_last), .rd_data(rd_data), .data_valid(data_valid),
    .data_last(data_last)
  );

  assign ind_n  = !(data_valid && data_last);
  assign ind_oe = !ce_n;

  AST_IND_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_n |-> data_valid); // R10
endmodule

// File: tb/test_bseq_top.sv
module test_bseq_top;
  localparam int AW = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic ce_n = 1'b1;
  logic adv_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] rd_addr;
  logic addr_valid;
  logic [31:0] rd_data;
  logic data_valid;
  logic ind_n;
  logic ind_oe;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bseq_top #(.AW(AW)) i_bseq_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ce_n(ce_n), .adv_n(adv_n), .start_addr(start_addr), .rd_addr(rd_addr),
    .addr_valid(addr_valid), .rd_data(rd_data), .data_valid(data_valid),
    .ind_n(ind_n), .ind_oe(ind_oe)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input int s, input int n, input int i);
    return (s / n) * n + ((s % n) + i) % n;
  endfunction

  task automatic write_cfg(input int lat, input logic [2:0] len);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 16'(lat << 10) | 16'(len);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int s);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; start_addr = AW'(s);
    @(posedge clk); #1;
    adv_n = 1'b1;
  endtask

  // Full burst: R4 timing, R5/R6 order, R10 end mark, R12 hold, R13 data
  task automatic run_burst(input int s, input int n, input int lat, input string tag);
    strobe(s);
    for (int k = 1; k <= lat + n + 2; k++) begin
      @(posedge clk); #1;
      if (k >= lat && k <= lat + n - 1) begin
        chk(addr_valid === 1'b1, {tag, " R4 addr_valid"}, 32'(addr_valid), 1);
        chk(rd_addr == AW'(exp_addr(s, n, k - lat)), {tag, " R5/R6 order"},
            32'(rd_addr), 32'(exp_addr(s, n, k - lat)));
      end else begin
        chk(addr_valid === 1'b0, {tag, " R4 idle addr"}, 32'(addr_valid), 0);
      end
      if (k >= lat + 1 && k <= lat + n) begin
        chk(data_valid === 1'b1, {tag, " R4 data_valid"}, 32'(data_valid), 1);
        chk(rd_data == 32'hC0DE0000 + 32'(exp_addr(s, n, k - lat - 1)) * 5,
            {tag, " R13 data"}, rd_data,
            32'hC0DE0000 + 32'(exp_addr(s, n, k - lat - 1)) * 5);
      end
      chk(ind_n === (k == lat + n ? 1'b0 : 1'b1), {tag, " R10 ind_n"},
          32'(ind_n), (k == lat + n) ? 0 : 1);
      if (k == lat + n + 2)
        chk(rd_addr == AW'(exp_addr(s, n, n - 1)), {tag, " R12 hold"},
            32'(rd_addr), 32'(exp_addr(s, n, n - 1)));
    end
  endtask

  task automatic t_reset;
    chk(addr_valid === 1'b0 && data_valid === 1'b0, "R1 reset valid",
        {30'd0, addr_valid, data_valid}, 0);
    chk(ind_n === 1'b1, "R1 reset ind_n", 32'(ind_n), 1);
    chk(ind_oe === 1'b0, "R11 deselected ind_oe", 32'(ind_oe), 0);
    run_burst(5, 8, 13, "R1 default");
    chk(ind_oe === 1'b1, "R11 selected ind_oe", 32'(ind_oe), 1);
  endtask

  task automatic t_cfg;
    write_cfg(3, 3'b010);
    run_burst(13, 4, 3, "R2 len4");
    write_cfg(15, 3'b011);
    run_burst(2, 4, 3, "R3 lat15");
    write_cfg(0, 3'b011);
    write_cfg(1, 3'b011);
    write_cfg(14, 3'b011);
    run_burst(7, 4, 3, "R3 lat0/1/14");
    write_cfg(2, 3'b011);
    run_burst(41, 8, 2, "R2 len8 lat2");
    run_burst(48, 8, 2, "R6 aligned");
  endtask

  task automatic t_disabled;
    for (int c = 4; c <= 7; c++) begin
      write_cfg(2, 3'(c == 7 ? 0 : c));
      strobe(9);
      for (int k = 0; k < 6; k++) begin
        @(posedge clk); #1;
        chk(addr_valid === 1'b0, "R7 disabled", 32'(addr_valid), 0);
      end
    end
  endtask

  task automatic t_restart;
    write_cfg(3, 3'b010);
    strobe(20);
    repeat (4) @(posedge clk);
    #1;
    chk(addr_valid === 1'b1, "R8 first burst live", 32'(addr_valid), 1);
    run_burst(37, 4, 3, "R8 restart");
  endtask

  task automatic t_abort;
    write_cfg(2, 3'b011);
    strobe(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    #1;
    chk(ind_oe === 1'b0, "R11 float on deselect", 32'(ind_oe), 0);
    @(posedge clk); #1;
    chk(addr_valid === 1'b0, "R9 abort", 32'(addr_valid), 0);
    @(negedge clk);
    ce_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      chk(addr_valid === 1'b0, "R9 stays idle", 32'(addr_valid), 0);
      chk(ind_n === 1'b1, "R10 no mark after abort", 32'(ind_n), 1);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_cfg();
    t_disabled();
    t_restart();
    t_abort();
    finish_run();
  end
endmodule